// File: doc/BRIEF.md
# Smart Card Clock Divider

This block produces the clock sent to a smart card from a reference clock (crystal oscillator or host clock, up to 27 MHz). A two-bit select input picks one of four ratios: divide by 8, 4 or 2, or the reference passed straight through. The select code follows a reflected ordering rather than a binary one. Every divided ratio gives an exact 50% duty cycle.

During a session the host can stop the card clock to put the card in its power-down state. It also chooses whether the parked clock sits low or high. A gate input from the session sequencer keeps the clock low whenever no session is active.

All decisions are taken on rising reference edges, and only at card-clock period boundaries. A ratio change, a stop or a release therefore never produces a runt pulse or a shortened phase. The pass-through ratio goes through a clock multiplexer that changes its enable only while the reference is low.

Top module: `sc_clkdiv_top`

## Requirements
- R1: While reset is asserted, and afterwards until the gate is raised, `card_clk` is low.
- R2: With `div_sel` = 2'b00, `card_clk` repeats every 8 reference cycles: high for 4 cycles starting at a reference rising edge, then low for 4.
- R3: With `div_sel` = 2'b01, `card_clk` is high for 2 and low for 2 reference cycles.
- R4: With `div_sel` = 2'b11, `card_clk` is high for 1 and low for 1 reference cycle.
- R5: With `div_sel` = 2'b10, `card_clk` follows the reference clock, high in each reference high half and low in each low half.
- R6: A new `div_sel` value is used only at the next period boundary, which is the rising edge that ends a complete low phase. A high phase in progress is never cut short or stretched by the change.
- R7: With `stop_req` = 1 and `stop_high` = 0, `card_clk` completes its current period and then stays low for as long as the stop request holds.
- R8: With `stop_req` = 1 and `stop_high` = 1, `card_clk` completes its current period, rises at the next boundary and stays high until the request is released.
- R9: When a high park ends, `card_clk` first drives a full low phase for the current ratio: N/2 reference cycles, and at least one cycle in pass-through. Only after that does normal toggling resume.
- R10: From the first rising reference edge at which `sess_gate` is sampled low, `card_clk` is low, whatever `stop_req`, `stop_high` and `div_sel` say. A pass-through high half that is already in progress completes.
- R11: On entry to pass-through, the low level lasts one extra reference cycle. The pass-through enable changes only while the reference is low, so the output never carries a partial reference pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all decisions on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio select: 00 /8, 01 /4, 11 /2, 10 pass-through |
| stop_req | input | 1 | Request to halt the card clock |
| stop_high | input | 1 | Parked level while halted: 0 low, 1 high |
| sess_gate | input | 1 | Session gate from the sequencer; low forces the clock low |
| card_clk | output | 1 | Clock to the card |

## Verification
The hardest situations to reach are those where control inputs change in the middle of a card-clock phase. Examples are a ratio change during the second cycle of a divide-by-8 high phase, a gate drop during a pass-through high half, and a high-park release while pass-through is selected. The stimulus changes inputs at fixed reference-cycle offsets that are deliberately not multiples of the active ratio. A behavioural model predicts the output for both halves of every reference cycle, so any truncated or stretched phase shows up as a mismatch in a single half-cycle.

// File: rtl/sc_clkdiv_pkg.sv
package sc_clkdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HI      = 3'd1,
        ST_LO      = 3'd2,
        ST_PASS    = 3'd3,
        ST_PARK_LO = 3'd4,
        ST_PARK_HI = 3'd5
    } sc_state_e;

    // Reflected select code to ratio rank: 0 slowest ... 3 pass-through
    function automatic logic [1:0] sc_rank(input logic [1:0] code);
        return {code[1], code[1] ^ code[0]};
    endfunction

endpackage

// File: rtl/sc_ratio_dec.sv
module sc_ratio_dec #(
    parameter int LOG2_MAX_DIV = 3,
    localparam int CW = LOG2_MAX_DIV
) (
    input  logic [1:0]    sel,
    output logic          pass,
    output logic [CW-1:0] half
);
    import sc_clkdiv_pkg::*;

    logic [CW-1:0] half_lut [4];
    logic          pass_lut [4];

    for (genvar c = 0; c < 4; c++) begin : g_code
        localparam int RANK = ((c >> 1) & 1) * 2 + (((c >> 1) ^ c) & 1);
        localparam int SH   = (RANK == 3) ? 0 : (LOG2_MAX_DIV - 1 - RANK);
        assign half_lut[c] = CW'(1) << SH;
        assign pass_lut[c] = (RANK == 3);
    end

    always_comb begin
        half = half_lut[sel];
        pass = pass_lut[sel];
    end

    // Decoder agrees with the reflected-code rank: rank 3 is the only pass code
    always_comb begin
        assert (pass == (sc_rank(sel) == 2'd3)); // R5
    end
endmodule

// File: rtl/sc_phase_core.sv
module sc_phase_core #(
    parameter int LOG2_MAX_DIV = 3,
    localparam int CW = LOG2_MAX_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          stop,
    input  logic          park_high,
    input  logic          sel_pass,
    input  logic [CW-1:0] sel_half,
    output logic          lvl,
    output logic          pass_req
);
    import sc_clkdiv_pkg::*;

    typedef struct packed {
        sc_state_e     st;
        logic          lvl;
        logic          pass;
        logic [CW-1:0] cnt;
        logic [CW-1:0] half;
    } core_t;

    core_t s_d, s_q;
    logic  boundary;

    function automatic core_t f_start(input core_t cur, input logic stp, input logic phi,
                                      input logic p, input logic [CW-1:0] h);
        core_t n;
        n      = cur;
        n.pass = 1'b0;
        n.cnt  = '0;
        if (stp) begin
            n.st  = phi ? ST_PARK_HI : ST_PARK_LO;
            n.lvl = phi;
        end else if (p) begin
            n.st   = ST_PASS;
            n.lvl  = 1'b0;
            n.pass = 1'b1;
        end else begin
            n.st   = ST_HI;
            n.lvl  = 1'b1;
            n.half = h;
            n.cnt  = h - CW'(1);
        end
        return n;
    endfunction

    always_comb begin
        boundary = (s_q.st == ST_IDLE) || (s_q.st == ST_PASS) || (s_q.st == ST_PARK_LO) ||
                   ((s_q.st == ST_LO) && (s_q.cnt == '0));
        s_d = s_q;
        if (!gate) begin
            s_d.st   = ST_IDLE;
            s_d.lvl  = 1'b0;
            s_d.pass = 1'b0;
            s_d.cnt  = '0;
        end else if (boundary) begin
            s_d = f_start(s_q, stop, park_high, sel_pass, sel_half);
        end else begin
            case (s_q.st)
                ST_HI: begin
                    if (s_q.cnt == '0) begin
                        s_d.st  = ST_LO;
                        s_d.lvl = 1'b0;
                        s_d.cnt = s_q.half - CW'(1);
                    end else begin
                        s_d.cnt = s_q.cnt - CW'(1);
                    end
                end
                ST_LO: s_d.cnt = s_q.cnt - CW'(1);
                ST_PARK_HI: begin
                    if (!(stop && park_high)) begin
                        s_d.st   = ST_LO;
                        s_d.lvl  = 1'b0;
                        s_d.half = sel_half;
                        s_d.cnt  = sel_half - CW'(1);
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.lvl  <= 1'b0;
            s_q.pass <= 1'b0;
            s_q.cnt  <= '0;
            s_q.half <= CW'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl      = s_q.lvl;
    assign pass_req = s_q.pass;

    AST_GATE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> (!lvl && !pass_req)); // R10

    AST_PARK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && stop && !park_high && s_q.st == ST_PARK_LO) |=> (!lvl && !pass_req)); // R7

    AST_PARK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && stop && park_high && s_q.st == ST_PARK_HI) |=> lvl); // R8

    AST_RISE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl) |-> $past(boundary)); // R6

    AST_RESUME_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st) == ST_PARK_HI && s_q.st == ST_LO) |-> (s_q.cnt == s_q.half - CW'(1))); // R9
endmodule

// File: rtl/sc_clk_mux.sv
module sc_clk_mux (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pass_req,
    input  logic div_lvl,
    output logic card_clk
);
    logic en_d, en_q;

    always_comb en_d = pass_req;

    // Enable changes on the falling edge, while the reference is low
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign card_clk = (ref_clk & en_q) | div_lvl;

    AST_PASS_EN_CLEAN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(en_q) |-> !div_lvl); // R11
endmodule

// File: rtl/sc_clkdiv_top.sv
module sc_clkdiv_top #(
    parameter int LOG2_MAX_DIV = 3
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       stop_req,
    input  logic       stop_high,
    input  logic       sess_gate,
    output logic       card_clk
);
    localparam int CW = LOG2_MAX_DIV;

    logic          sel_pass;
    logic [CW-1:0] sel_half;
    logic          lvl, pass_req;

    sc_ratio_dec #(.LOG2_MAX_DIV(LOG2_MAX_DIV)) u_dec (
        .sel (div_sel),
        .pass(sel_pass),
        .half(sel_half)
    );

    sc_phase_core #(.LOG2_MAX_DIV(LOG2_MAX_DIV)) u_core (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .gate     (sess_gate),
        .stop     (stop_req),
        .park_high(stop_high),
        .sel_pass (sel_pass),
        .sel_half (sel_half),
        .lvl      (lvl),
        .pass_req (pass_req)
    );

    sc_clk_mux u_mux (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pass_req(pass_req),
        .div_lvl (lvl),
        .card_clk(card_clk)
    );

    AST_RESET_QUIET: assert property (@(posedge ref_clk) !rst_n |-> !card_clk); // R1
endmodule

// File: tb/tb_sc_clkdiv_top.sv
module tb_sc_clkdiv_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       stop_req = 1'b0;
    logic       stop_high = 1'b0;
    logic       sess_gate = 1'b0;
    logic       card_clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    sc_clkdiv_top dut (
        .ref_clk(clk), .rst_n(rst_n), .div_sel(div_sel), .stop_req(stop_req),
        .stop_high(stop_high), .sess_gate(sess_gate), .card_clk(card_clk)
    );

    always #4 clk = ~clk;

    // Behavioural model: kinds 0 idle, 1 high, 2 low, 3 pass, 4 parked low, 5 parked high
    int m_kind = 0, m_left = 0, m_half = 1;
    bit m_lvl = 0, m_pass = 0, was_pass = 0;
    bit exp_hi = 0, exp_lo = 0;

    function automatic int half_for(logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 2;
            2'b11:   return 1;
            default: return 1;
        endcase
    endfunction

    task automatic m_begin_period();
        m_pass = 0;
        m_left = 0;
        if (stop_req) begin
            m_kind = stop_high ? 5 : 4;
            m_lvl  = stop_high;
        end else if (div_sel == 2'b10) begin
            m_kind = 3; m_lvl = 0; m_pass = 1;
        end else begin
            m_kind = 1; m_lvl = 1;
            m_half = half_for(div_sel);
            m_left = m_half - 1;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_kind = 0; m_left = 0; m_half = 1; m_lvl = 0; m_pass = 0;
            exp_hi = 0; exp_lo = 0;
        end else begin
            was_pass = m_pass;
            if (!sess_gate) begin
                m_kind = 0; m_lvl = 0; m_pass = 0; m_left = 0;
            end else if (m_kind == 1) begin
                if (m_left == 0) begin m_kind = 2; m_lvl = 0; m_left = m_half - 1; end
                else m_left--;
            end else if (m_kind == 2) begin
                if (m_left == 0) m_begin_period();
                else m_left--;
            end else if (m_kind == 5) begin
                if (!(stop_req && stop_high)) begin
                    m_kind = 2; m_lvl = 0;
                    m_half = half_for(div_sel);
                    m_left = m_half - 1;
                end
            end else begin
                m_begin_period();
            end
            exp_hi = was_pass | m_lvl;
            exp_lo = m_lvl;
        end
    end

    task automatic compare(input bit expv, input string half_name);
        n_vec++;
        if (card_clk !== expv) begin
            n_bad++;
            $display("FAIL %s (%s half) t=%0t: card_clk=%0b expected %0b",
                     cur_req, half_name, $time, card_clk, expv);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) compare(exp_hi, "high");
    end

    always @(negedge clk) begin
        #2;
        if (!done) compare(exp_lo, "low");
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL R1 watchdog: run still active, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset and idle gate
        step(3);
        n_vec++;
        if (card_clk !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: card_clk=%0b expected 0", card_clk);
        end
        rst_n = 1'b1;
        step(5);

        cur_req = "R2"; sess_gate = 1'b1; div_sel = 2'b00; step(40);
        cur_req = "R3"; div_sel = 2'b01; step(24);
        cur_req = "R4"; div_sel = 2'b11; step(16);
        cur_req = "R5"; div_sel = 2'b10; step(16);

        cur_req = "R11"; div_sel = 2'b00; step(13);
        div_sel = 2'b10; step(5);
        div_sel = 2'b01; step(11);
        div_sel = 2'b10; step(3);
        div_sel = 2'b11; step(6);

        cur_req = "R6"; div_sel = 2'b00; step(10);
        div_sel = 2'b11; step(1);
        div_sel = 2'b00; step(3);
        div_sel = 2'b01; step(9);
        div_sel = 2'b00; step(1);
        div_sel = 2'b11; step(12);

        cur_req = "R7"; div_sel = 2'b00; step(5);
        stop_req = 1'b1; stop_high = 1'b0; step(20);
        stop_req = 1'b0; step(19);
        div_sel = 2'b10; stop_req = 1'b1; step(6);
        stop_req = 1'b0; step(6);

        cur_req = "R8"; div_sel = 2'b00; step(3);
        stop_req = 1'b1; stop_high = 1'b1; step(20);
        stop_high = 1'b0; step(9);
        stop_high = 1'b1; step(9);

        cur_req = "R9"; stop_req = 1'b0; step(20);
        div_sel = 2'b10; stop_req = 1'b1; step(6);
        stop_req = 1'b0; step(10);
        div_sel = 2'b11; stop_req = 1'b1; step(5);
        stop_req = 1'b0; step(10);
        div_sel = 2'b01; stop_req = 1'b1; step(7);
        stop_req = 1'b0; step(10);

        cur_req = "R10"; stop_req = 1'b1; stop_high = 1'b1; div_sel = 2'b00; step(10);
        sess_gate = 1'b0; step(10);
        sess_gate = 1'b1; stop_req = 1'b0; div_sel = 2'b10; step(6);
        sess_gate = 1'b0; step(6);
        sess_gate = 1'b1; div_sel = 2'b00; step(2);
        sess_gate = 1'b0; step(5);
        sess_gate = 1'b1; step(20);

        step(1);
        finish_run();
    end
endmodule